// File: doc/BRIEF.md
# Descending Boot Page Loader

After a boot start pulse, this block copies one page of a byte-wide external EPROM into on-chip program memory. Program memory holds 24-bit words. The loader first reads a length byte from the selected page. It then walks the page backwards from its last word to word 0, fetching three bytes for each word. Each set of three bytes is assembled into one 24-bit word, which is written to program memory at the same index it came from. This fills program memory from the top down. A one-cycle done pulse marks the end of the copy.

Every EPROM byte address is formed by concatenating four fields:

- the boot page that was sampled at start;
- the high part of the word index, which begins at the page length;
- a 3-bit low word counter;
- a 2-bit byte code.

The bytes of a word are not fetched in ascending order. The upper byte comes first, then the lower byte, then the middle byte. The EPROM read port uses a request/acknowledge handshake, so the loader works with any read latency.

Top module: `boot_page_loader`

## Requirements
- R1: While reset is high and in the first cycle after it, `rd_req_o`, `pm_we_o` and `boot_done_o` are low.
- R2: The first read after an accepted start goes to byte offset 3 of the selected page, at address {page, 11'b0, 2'b11}. For page 0 this is 0x0003. The byte returned is the page length L.
- R3: Every other read address is {page[15:13], word index[12:2], byte code[1:0]}. The word index runs from 8·(L+1)−1 down to 0. L = 0 gives eight words.
- R4: The three reads for one word use byte codes 00 (upper), 10 (lower), 01 (middle), in that order. Code 11 is never used for a word byte.
- R5: A read request stays high with a stable address until `rd_ack_i` is seen high. Only then does the address advance.
- R6: Each written word is {upper byte, middle byte, lower byte}, in bits [23:16], [15:8] and [7:0].
- R7: `pm_we_o` pulses for one cycle in the cycle after the middle byte is acknowledged, with `pm_addr_o` equal to that word's index. Writes therefore go from 8·(L+1)−1 down to 0.
- R8: `boot_done_o` pulses for exactly one cycle, in the cycle after the word-0 write. No read request is raised after the word-0 middle byte until the next start.
- R9: A start pulse that arrives while a boot is in progress has no effect on the address, write or done sequence. After the boot ends, it does not cause a second boot.
- R10: The page is sampled on the accepted start. Later changes to `boot_page_i` during the boot have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_start_i | input | 1 | Start pulse |
| boot_page_i | input | 3 | EPROM page to copy |
| rd_req_o | output | 1 | EPROM byte read request |
| rd_addr_o | output | 16 | EPROM byte address |
| rd_ack_i | input | 1 | Read acknowledge, with data valid |
| rd_data_i | input | 8 | EPROM data byte |
| pm_we_o | output | 1 | Program memory write strobe |
| pm_addr_o | output | 11 | Program memory word address |
| pm_wdata_o | output | 24 | Program memory write data |
| boot_done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench runs four boots, each of which tells a different fault apart:

- **Page 0, length 0, back-to-back acknowledges.** This reproduces the minimal eight-word sequence starting 0x0003, 0x001C, 0x001E, 0x001D. It shows whether the byte order or the word order is wrong.
- **Page 5, length 2, acknowledges delayed by zero to three cycles.** This separates a loader that waits for the handshake from one that advances on its own. It also exposes wrong page bits and wrong high word-index bits.
- **Page 7, length 1, disturbed.** A second start pulse is sent and the page input is changed mid-boot. A loader that restarts or re-samples the page then shows a diverging address stream.
- **Page 3, length 255.** This exercises the longest page and the wrap of the 3-bit counter into the length field.

// File: rtl/boot_ldr_pkg.sv
package boot_ldr_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_LEN   = 2'd1,
    S_BYTES = 2'd2,
    S_FIN   = 2'd3
  } ldr_state_t;

  // byte codes in the two address LSBs
  localparam logic [1:0] BC_UPPER  = 2'b00;
  localparam logic [1:0] BC_LOWER  = 2'b10;
  localparam logic [1:0] BC_MIDDLE = 2'b01;
  localparam logic [1:0] BC_LENGTH = 2'b11;

  // fetch order within a word: upper, lower, middle
  function automatic logic [1:0] next_byte_code(input logic [1:0] c);
    case (c)
      BC_UPPER: return BC_LOWER;
      BC_LOWER: return BC_MIDDLE;
      default:  return BC_UPPER;
    endcase
  endfunction

endpackage

// File: rtl/boot_addr_gen.sv
module boot_addr_gen #(
  parameter int PAGE_W = 3,
  parameter int IDX_W  = 11,
  localparam int ADDR_W = PAGE_W + IDX_W + 2
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [1:0]        code_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [2:0]        lane_o   // {upper, middle, lower}
);
  import boot_ldr_pkg::*;

  always_comb begin
    addr_o = {page_i, idx_i, code_i};
    case (code_i)
      BC_UPPER:  lane_o = 3'b100;
      BC_MIDDLE: lane_o = 3'b010;
      BC_LOWER:  lane_o = 3'b001;
      default:   lane_o = 3'b000;
    endcase
  end

endmodule

// File: rtl/boot_word_asm.sv
module boot_word_asm #(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 11,
  localparam int WORD_W = 3 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,   // byte accepted this cycle
  input  logic [2:0]        lane_i,   // {upper, middle, lower}
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              pm_we_o,
  output logic [IDX_W-1:0]  pm_addr_o,
  output logic [WORD_W-1:0] pm_wdata_o
);

  logic [BYTE_W-1:0] upper_q, lower_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q    <= '0;
      lower_q    <= '0;
      pm_we_o    <= 1'b0;
      pm_addr_o  <= '0;
      pm_wdata_o <= '0;
    end else begin
      pm_we_o <= 1'b0;
      if (take_i) begin
        if (lane_i[2]) upper_q <= data_i;
        if (lane_i[0]) lower_q <= data_i;
        if (lane_i[1]) begin
          // middle byte is fetched last: word complete
          pm_we_o    <= 1'b1;
          pm_addr_o  <= idx_i;
          pm_wdata_o <= {upper_q, data_i, lower_q};
        end
      end
    end
  end

  // three acknowledged bytes separate two writes
  assert_we_spacing_R7: assert property (@(posedge clk) disable iff (rst)
    pm_we_o |=> !pm_we_o);

endmodule

// File: rtl/boot_seq.sv
module boot_seq #(
  parameter int PAGE_W = 3,
  parameter int LEN_W  = 8,   // must not exceed BYTE_W
  parameter int CNT_W  = 3,
  parameter int BYTE_W = 8,
  localparam int IDX_W = LEN_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] page_sel_i,
  input  logic              rd_ack_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [1:0]        code_o,
  output logic              rd_req_o,
  output logic              take_o,
  output logic              done_o
);
  import boot_ldr_pkg::*;

  ldr_state_t        state_q;
  logic [PAGE_W-1:0] page_q;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        code_q;
  logic              req_q, done_q;
  logic              acc;

  assign acc    = req_q && rd_ack_i;
  assign take_o = acc && (state_q == S_BYTES);
  assign page_o = page_q;
  assign idx_o  = idx_q;
  assign code_o = code_q;
  assign rd_req_o = req_q;
  assign done_o   = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      page_q  <= '0;
      idx_q   <= '0;
      code_q  <= BC_LENGTH;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start_i) begin
            page_q  <= page_sel_i;
            idx_q   <= '0;
            code_q  <= BC_LENGTH;
            req_q   <= 1'b1;
            state_q <= S_LEN;
          end
        end
        S_LEN: begin
          if (acc) begin
            idx_q   <= {rd_data_i[LEN_W-1:0], {CNT_W{1'b1}}};
            code_q  <= BC_UPPER;
            state_q <= S_BYTES;
          end
        end
        S_BYTES: begin
          if (acc) begin
            code_q <= next_byte_code(code_q);
            if (code_q == BC_MIDDLE) begin
              if (idx_q == '0) begin
                req_q   <= 1'b0;
                state_q <= S_FIN;
              end else begin
                idx_q <= idx_q - 1'b1;
              end
            end
          end
        end
        default: begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
      endcase
    end
  end

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE) |-> !req_q);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (req_q && !rd_ack_i) |=> (req_q && $stable(idx_q) && $stable(code_q) && $stable(page_q)));

  assert_code_legal_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_BYTES) |-> (code_q != BC_LENGTH));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

endmodule

// File: rtl/boot_page_loader.sv
module boot_page_loader #(
  parameter int PAGE_W = 3,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 3,
  parameter int BYTE_W = 8,
  localparam int IDX_W  = LEN_W + CNT_W,
  localparam int ADDR_W = PAGE_W + IDX_W + 2,
  localparam int WORD_W = 3 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_start_i,
  input  logic [PAGE_W-1:0] boot_page_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              pm_we_o,
  output logic [IDX_W-1:0]  pm_addr_o,
  output logic [WORD_W-1:0] pm_wdata_o,
  output logic              boot_done_o
);

  logic [PAGE_W-1:0] page;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        code;
  logic [2:0]        lane;
  logic              take;

  boot_seq #(
    .PAGE_W(PAGE_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .start_i(boot_start_i), .page_sel_i(boot_page_i),
    .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .page_o(page), .idx_o(idx), .code_o(code),
    .rd_req_o(rd_req_o), .take_o(take), .done_o(boot_done_o)
  );

  boot_addr_gen #(.PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_addr (
    .page_i(page), .idx_i(idx), .code_i(code),
    .addr_o(rd_addr_o), .lane_o(lane)
  );

  boot_word_asm #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_asm (
    .clk(clk), .rst(rst),
    .take_i(take), .lane_i(lane), .idx_i(idx), .data_i(rd_data_i),
    .pm_we_o(pm_we_o), .pm_addr_o(pm_addr_o), .pm_wdata_o(pm_wdata_o)
  );

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (rst)
    boot_done_o |-> ($past(pm_we_o) && ($past(pm_addr_o) == '0)));

  assert_no_write_with_req_idle_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(pm_we_o) |-> $past(rd_req_o && rd_ack_i));

endmodule

// File: tb/boot_page_loader_tb.sv
`timescale 1ns/1ps
module boot_page_loader_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        boot_start_i = 1'b0;
  logic [2:0]  boot_page_i = '0;
  logic        rd_req_o;
  logic [15:0] rd_addr_o;
  logic        rd_ack_i = 1'b0;
  logic [7:0]  rd_data_i = '0;
  logic        pm_we_o;
  logic [10:0] pm_addr_o;
  logic [23:0] pm_wdata_o;
  logic        boot_done_o;

  always #2.5 clk = ~clk;

  boot_page_loader u_dut (
    .clk(clk), .rst(rst),
    .boot_start_i(boot_start_i), .boot_page_i(boot_page_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .pm_we_o(pm_we_o), .pm_addr_o(pm_addr_o), .pm_wdata_o(pm_wdata_o),
    .boot_done_o(boot_done_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0]  cur_len = '0;
  int          lat_mode = 0;
  int          wait_left = 0;
  int          req_num = 0;
  int          done_cnt = 0;
  bit          prev_we = 0;
  logic [10:0] prev_we_addr = '0;
  bit          monitor_on = 0;

  logic [15:0] req_q[$];
  int          kind_q[$];     // 2 = length read, 3 = word byte
  logic [34:0] wr_q[$];       // {addr, data}

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // EPROM model: offset 3 of any page holds the page length
  function automatic logic [7:0] rom(input logic [15:0] a);
    if (a[12:0] == 13'd3) return cur_len;
    return a[7:0] ^ {a[15:13], a[12:8]} ^ 8'h5C;
  endfunction

  function automatic int next_lat(input int n);
    if (lat_mode == 0) return 0;
    return n % 4;
  endfunction

  // reference: expected request and write streams
  task automatic build_model(input logic [2:0] pg, input logic [7:0] len);
    int nwords;
    logic [15:0] a;
    logic [7:0] up, lo, mi;
    req_q.delete(); kind_q.delete(); wr_q.delete();
    req_q.push_back({pg, 11'd0, 2'b11});
    kind_q.push_back(2);
    nwords = (int'(len) + 1) * 8;
    for (int w = nwords - 1; w >= 0; w--) begin
      a = {pg, 11'(w), 2'b00}; up = rom(a); req_q.push_back(a); kind_q.push_back(3);
      a = {pg, 11'(w), 2'b10}; lo = rom(a); req_q.push_back(a); kind_q.push_back(3);
      a = {pg, 11'(w), 2'b01}; mi = rom(a); req_q.push_back(a); kind_q.push_back(3);
      wr_q.push_back({11'(w), up, mi, lo});
    end
  endtask

  // cycle-by-cycle comparison and EPROM responder
  always @(negedge clk) begin
    if (!rst && monitor_on) begin
      rd_ack_i = 1'b0;
      if (rd_req_o) begin
        if (req_q.size() == 0) begin
          chk(1'b0, "R9 unexpected read", 32'(rd_addr_o), 32'hFFFF);
        end else if (wait_left > 0) begin
          chk(rd_addr_o == req_q[0], "R5 address held", 32'(rd_addr_o), 32'(req_q[0]));
          wait_left--;
        end else begin
          if (kind_q[0] == 2)
            chk(rd_addr_o == req_q[0], "R2 length read", 32'(rd_addr_o), 32'(req_q[0]));
          else
            chk(rd_addr_o == req_q[0], "R3 R4 byte addr", 32'(rd_addr_o), 32'(req_q[0]));
          rd_ack_i  = 1'b1;
          rd_data_i = rom(req_q[0]);
          void'(req_q.pop_front());
          void'(kind_q.pop_front());
          req_num++;
          wait_left = next_lat(req_num);
        end
      end
      if (pm_we_o) begin
        if (wr_q.size() == 0) begin
          chk(1'b0, "R7 unexpected write", 32'(pm_addr_o), 32'h7FF);
        end else begin
          chk(pm_addr_o == wr_q[0][34:24], "R7 write addr", 32'(pm_addr_o), 32'(wr_q[0][34:24]));
          chk(pm_wdata_o == wr_q[0][23:0], "R6 write data", 32'(pm_wdata_o), 32'(wr_q[0][23:0]));
          void'(wr_q.pop_front());
        end
      end
      if (boot_done_o) begin
        done_cnt++;
        chk(prev_we && prev_we_addr == 11'd0 && wr_q.size() == 0, "R8 done timing",
            {31'd0, prev_we}, 32'd1);
      end
      prev_we      = pm_we_o;
      prev_we_addr = pm_addr_o;
    end
  end

  task automatic run_boot(input logic [2:0] pg, input logic [7:0] len, input int lat, input bit disturb);
    int cyc;
    cur_len = len;
    lat_mode = lat;
    wait_left = 0;
    done_cnt = 0;
    build_model(pg, len);
    @(negedge clk);
    boot_page_i  = pg;
    boot_start_i = 1'b1;
    @(negedge clk);
    boot_start_i = 1'b0;
    cyc = 0;
    while (done_cnt == 0 && cyc < 40000) begin
      @(negedge clk);
      cyc++;
      if (disturb) begin
        if (cyc == 30) begin boot_start_i = 1'b1; boot_page_i = ~pg; end  // R9 R10
        if (cyc == 31) boot_start_i = 1'b0;
      end
    end
    if (done_cnt == 0) chk(1'b0, "R8 boot never finished", 32'(cyc), 32'd0);
    repeat (12) @(negedge clk);
    chk(done_cnt == 1, "R8 single done", 32'(done_cnt), 32'd1);
    chk(req_q.size() == 0, "R3 all bytes read", 32'(req_q.size()), 32'd0);
    chk(wr_q.size() == 0, "R7 all words written", 32'(wr_q.size()), 32'd0);
    chk(rd_req_o == 1'b0, "R9 R8 idle after boot", {31'd0, rd_req_o}, 32'd0);
    boot_page_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!rd_req_o && !pm_we_o && !boot_done_o, "R1 reset outputs",
        {29'd0, rd_req_o, pm_we_o, boot_done_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!rd_req_o && !pm_we_o && !boot_done_o, "R1 after reset",
        {29'd0, rd_req_o, pm_we_o, boot_done_o}, 32'd0);
    monitor_on = 1;
    run_boot(3'd0, 8'd0, 0, 1'b0);   // minimal page, back-to-back
    run_boot(3'd5, 8'd2, 1, 1'b0);   // delayed acknowledges
    run_boot(3'd7, 8'd1, 1, 1'b1);   // start and page change mid-boot
    run_boot(3'd3, 8'd255, 0, 1'b0); // longest page
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule